// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a panel pixel clock from a faster source clock. The division ratio is a fixed-point number with four fractional bits, so it equals the source frequency times sixteen over the pixel frequency. A phase accumulator advances by one whole source cycle (sixteen sixteenths) on every source edge. When the accumulated phase reaches the active ratio, the block ends a pixel period and keeps the remainder. Because of this, individual periods are a whole number of source cycles long, but their long-term average is exactly the programmed ratio.

Two outputs leave the block. The first is a one-cycle pixel enable for logic clocked by the source clock. The second is a pixel clock waveform that rises at the start of each period and falls at a programmable point. That point is given in quarter source cycles, which is two fewer fractional bits than the ratio. The nominal setting for a square wave is the ratio divided by eight, minus one. Software supplies both values. The block clamps the ratio into its legal range, and it takes a new ratio and a new falling point only at a period boundary.

Top module: `pix_clk_frac_div`

## Requirements
- R1: While reset is asserted, `pix_en` and `pix_clk` are both 0. The first period after reset always uses the minimum ratio, 0x40, so the first `pix_en` appears after the 4th rising source edge following reset release.
- R2: Let S(m) be the sum of the clamped ratios of periods 1..m. The m-th `pix_en` is high for one cycle after rising edge n, where n is the first edge with 16·n ≥ S(m). The average period is therefore exactly ratio/16 source cycles.
- R3: A `div_cfg` value below 0x40 behaves exactly as 0x40, which gives a period of 4 source cycles.
- R4: The top code 0xFFF is accepted unchanged and gives an average period of 255.9375 source cycles.
- R5: `pix_clk` rises only in the cycle in which `pix_en` is high, and it is high in every such cycle.
- R6: After a boundary, `pix_clk` goes low at the first edge at which floor(phase/4) ≥ `fall_cfg`+1. Here phase is the accumulated sixteenths since the boundary, remainder included. If that point is never reached, `pix_clk` stays high for the whole period.
- R7: `div_cfg` and `fall_cfg` are sampled only on the edge that ends a period. Changes in the middle of a period do not alter that period.
- R8: `pix_en` is never high in two consecutive cycles, and the spacing between pulses lies between 4 and 256 source cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | DIV_W (12) | Division ratio, 4 fractional bits |
| fall_cfg | input | DIV_W-FRAC_W+2 (10) | Falling-edge point in quarter source cycles, minus one |
| pix_en | output | 1 | One-cycle pulse at each pixel period start |
| pix_clk | output | 1 | Generated pixel clock waveform |

## Verification
The bench uses the default build: a 12-bit ratio, 4 fractional bits, and a clamp range of 0x40..0xFFF. With these values, every ratio from 0 to 0x7F can be swept in a few thousand cycles. That sweep covers the lower clamp and every fractional step, and the largest ratios still fit in a short run. Expected pulse edges come from the cumulative-sum rule. Expected falling edges come from quarter-cycle phase arithmetic. Run lengths are deliberately not aligned to periods, so configuration changes land mid-period and exercise the sampling at the boundary.

// File: rtl/pxdiv_pkg.sv
package pxdiv_pkg;
   // default geometry of the divider
   localparam int PXD_DIV_W   = 12;
   localparam int PXD_FRAC_W  = 4;
   localparam int PXD_DIV_MIN = 64;
   localparam int PXD_DIV_MAX = 4095;
   // falling point carries two fraction bits (quarter cycles)
   localparam int PXD_EDGE_FRAC = 2;
endpackage

// File: rtl/pxdiv_clamp.sv
module pxdiv_clamp #(
   parameter int W  = 12,
   parameter int LO = 64,
   parameter int HI = 4095
) (
   input  logic [W-1:0] raw,
   output logic [W-1:0] lim
);
   localparam logic [W-1:0] LO_V = W'(LO);
   localparam logic [W-1:0] HI_V = W'(HI);

   generate
      if (HI < (2**W) - 1) begin : g_both
         always_comb begin
            if (raw < LO_V)      lim = LO_V;
            else if (raw > HI_V) lim = HI_V;
            else                 lim = raw;
         end
      end else begin : g_low_only
         always_comb lim = (raw < LO_V) ? LO_V : raw;
      end
   endgenerate
endmodule

// File: rtl/pxdiv_phase.sv
module pxdiv_phase #(
   parameter int DIV_W   = 12,
   parameter int FRAC_W  = 4,
   parameter int DIV_MIN = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_lim,
   output logic             wrap,
   output logic [DIV_W:0]   ph_nxt,
   output logic             en_q
);
   localparam int PH_W = DIV_W + 1;
   localparam logic [PH_W-1:0] STEP = PH_W'(2**FRAC_W);

   logic [PH_W-1:0]  ph_q;
   logic [DIV_W-1:0] cur_q;

   always_comb begin
      ph_nxt = ph_q + STEP;
      wrap   = (ph_nxt >= {1'b0, cur_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         cur_q <= DIV_W'(DIV_MIN);
         en_q  <= 1'b0;
      end else begin
         en_q <= wrap;
         if (wrap) begin
            ph_q  <= ph_nxt - {1'b0, cur_q};
            cur_q <= div_lim;
         end else begin
            ph_q  <= ph_nxt;
         end
      end
   end
endmodule

// File: rtl/pxdiv_wave.sv
module pxdiv_wave #(
   parameter int PH_W     = 13,
   parameter int FALL_W   = 10,
   parameter int Q_SH     = 2,
   parameter int FALL_RST = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wrap,
   input  logic [PH_W-1:0]   ph_nxt,
   input  logic [FALL_W-1:0] fall_in,
   output logic              clk_q
);
   logic [FALL_W-1:0] fall_q;
   logic [FALL_W:0]   thresh;
   logic [PH_W-1:0]   th_ph;
   logic              low_hit;

   always_comb begin
      thresh  = {1'b0, fall_q} + 1'b1;
      th_ph   = PH_W'(thresh) << Q_SH;
      low_hit = (ph_nxt >= th_ph);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q  <= 1'b0;
         fall_q <= FALL_W'(FALL_RST);
      end else if (wrap) begin
         clk_q  <= 1'b1;
         fall_q <= fall_in;
      end else if (low_hit) begin
         clk_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/pix_clk_frac_div.sv
module pix_clk_frac_div
   import pxdiv_pkg::*;
#(
   parameter int DIV_W   = PXD_DIV_W,
   parameter int FRAC_W  = PXD_FRAC_W,
   parameter int DIV_MIN = PXD_DIV_MIN,
   parameter int DIV_MAX = PXD_DIV_MAX
) (
   input  logic                          clk_src,
   input  logic                          rst_n,
   input  logic [DIV_W-1:0]              div_cfg,
   input  logic [DIV_W-FRAC_W+1:0]       fall_cfg,
   output logic                          pix_en,
   output logic                          pix_clk
);
   localparam int PH_W     = DIV_W + 1;
   localparam int FALL_W   = DIV_W - FRAC_W + PXD_EDGE_FRAC;
   localparam int Q_SH     = FRAC_W - PXD_EDGE_FRAC;
   localparam int FALL_RST = (DIV_MIN >> (FRAC_W - 1)) - 1;

   generate
      if (FRAC_W < PXD_EDGE_FRAC) begin : g_bad_frac
         $error("FRAC_W must be at least the edge fraction width");
      end
      if (DIV_MIN < 2 * (2**FRAC_W)) begin : g_bad_min
         $error("DIV_MIN must span at least two source cycles");
      end
      if (DIV_MAX > (2**DIV_W) - 1 || DIV_MAX < DIV_MIN) begin : g_bad_max
         $error("DIV_MAX out of range");
      end
   endgenerate

   logic [DIV_W-1:0] div_lim;
   logic             wrap;
   logic [PH_W-1:0]  ph_nxt;

   pxdiv_clamp #(.W(DIV_W), .LO(DIV_MIN), .HI(DIV_MAX)) clamp_i (
      .raw (div_cfg),
      .lim (div_lim)
   );

   pxdiv_phase #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .DIV_MIN(DIV_MIN)) phase_i (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .div_lim (div_lim),
      .wrap    (wrap),
      .ph_nxt  (ph_nxt),
      .en_q    (pix_en)
   );

   pxdiv_wave #(.PH_W(PH_W), .FALL_W(FALL_W), .Q_SH(Q_SH), .FALL_RST(FALL_RST)) wave_i (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .wrap    (wrap),
      .ph_nxt  (ph_nxt),
      .fall_in (fall_cfg),
      .clk_q   (pix_clk)
   );
endmodule

// File: rtl/pix_clk_frac_div_chk.sv
module pix_clk_frac_div_chk #(
   parameter int DIV_W   = 12,
   parameter int FRAC_W  = 4,
   parameter int DIV_MIN = 64,
   parameter int DIV_MAX = 4095
) (
   input logic clk,
   input logic rst_n,
   input logic pix_en,
   input logic pix_clk
);
   localparam int MIN_CYC = DIV_MIN >> FRAC_W;
   localparam int MAX_CYC = (DIV_MAX + (2**FRAC_W) - 1) >> FRAC_W;
   localparam int CNT_W   = DIV_W - FRAC_W + 2;

   logic [CNT_W-1:0] gap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    gap_cnt <= '0;
      else if (pix_en)               gap_cnt <= '0;
      else if (gap_cnt != '1)        gap_cnt <= gap_cnt + 1'b1;
   end

   // R8
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en |=> !pix_en);

   // R8
   gap_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en |-> (gap_cnt >= CNT_W'(MIN_CYC - 1)));

   // R8
   gap_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en |-> (gap_cnt <= CNT_W'(MAX_CYC)));

   // R5
   rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pix_clk) |-> pix_en);

   // R5
   high_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en |-> pix_clk);
endmodule

bind pix_clk_frac_div pix_clk_frac_div_chk #(
   .DIV_W(DIV_W), .FRAC_W(FRAC_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
) chk_i (
   .clk     (clk_src),
   .rst_n   (rst_n),
   .pix_en  (pix_en),
   .pix_clk (pix_clk)
);

// File: tb/pix_clk_frac_div_tb_top.sv
`timescale 1ns/1ps
module pix_clk_frac_div_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [11:0] div_drv = 12'h050;
   logic [9:0]  fall_drv = 10'd9;
   logic       pix_en, pix_clk;

   int  vectors = 0;
   int  fails = 0;
   bit  done = 1'b0;

   // bench model state
   int     n = 0;
   longint s_sum = 0;
   int     d_cur = 64;
   int     f_cur = 7;
   bit     exp_clk = 1'b0;
   bit     prev_en = 1'b0;
   int     first_pulse = -1;

   always #5 clk = ~clk;

   pix_clk_frac_div dut_i (
      .clk_src  (clk),
      .rst_n    (rst_n),
      .div_cfg  (div_drv),
      .fall_cfg (fall_drv),
      .pix_en   (pix_en),
      .pix_clk  (pix_clk)
   );

   function automatic int clampd(input int d);
      return (d < 64) ? 64 : ((d > 4095) ? 4095 : d);
   endfunction

   function automatic int nom_fall(input int d);
      return clampd(d) / 8 - 1;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s at edge %0d: actual %0d expected %0d",
                  tag, what, n, act, exp);
      end
   endtask

   task automatic step(input string tag);
      bit exp_en;
      longint ph;
      @(negedge clk);
      n++;
      exp_en = (64'(16) * n >= s_sum + d_cur);
      if (exp_en) begin
         s_sum   = s_sum + d_cur;
         d_cur   = clampd(int'(div_drv));
         f_cur   = int'(fall_drv);
         exp_clk = 1'b1;
      end else begin
         ph = 64'(16) * n - s_sum;
         if ((ph >> 2) >= f_cur + 1) exp_clk = 1'b0;
      end
      if (pix_en && first_pulse < 0) first_pulse = n;
      chk(pix_en == exp_en, tag, "pix_en", int'(pix_en), int'(exp_en));
      chk(pix_clk == exp_clk, tag, "pix_clk", int'(pix_clk), int'(exp_clk));
      // R5: clock high in every enable cycle
      chk(!pix_en || pix_clk, "R5", "pix_clk at pix_en", int'(pix_clk), 1);
      // R8: no back-to-back enables
      chk(!(pix_en && prev_en), "R8", "consecutive pix_en", 1, 0);
      prev_en = pix_en;
   endtask

   task automatic run(input int d, input int f, input int cyc, input string tag);
      div_drv  = 12'(d);
      fall_drv = 10'(f);
      repeat (cyc) step(tag);
   endtask

   initial begin
      // R1: reset state
      repeat (4) begin
         @(negedge clk);
         chk(pix_en == 1'b0 && pix_clk == 1'b0, "R1", "reset outputs",
             int'({pix_en, pix_clk}), 0);
      end
      rst_n = 1'b1;
      // R1: first period uses the minimum ratio
      run(12'h050, nom_fall(12'h050), 6, "R1");
      chk(first_pulse == 4, "R1", "first pulse edge", first_pulse, 4);
      // R2: fractional ratios, average exact
      run(12'h048, nom_fall(12'h048), 73, "R2");
      run(12'h05B, nom_fall(12'h05B), 91, "R2");
      // R3 / R2: sweep every code 0..0x7F including codes below the clamp
      for (int d = 0; d < 128; d++) begin
         run(d, nom_fall(d), 23, (d < 64) ? "R3" : "R2");
      end
      // R4: top code
      run(12'hFFF, nom_fall(12'hFFF), 1100, "R4");
      run(12'h800, nom_fall(12'h800), 333, "R2");
      run(12'h123, nom_fall(12'h123), 101, "R2");
      // R6: falling point variants
      run(12'h080, 0, 37, "R6");
      run(12'h080, 1023, 41, "R6");
      run(12'h0A7, 2, 45, "R6");
      run(12'h0A7, 30, 45, "R6");
      // R7: mid-period changes with short unaligned runs
      for (int k = 0; k < 40; k++) begin
         run((k % 2) ? 12'h0C3 : 12'h04D, (k % 3) * 5, 3 + (k % 5), "R7");
      end
      run(12'h064, nom_fall(12'h064), 30, "R7");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule